// File: doc/BRIEF.md
# Host Wake and Message Doorbell Register Block

This block sits on the device side of a host register interface. It handles the host's wake and sleep handshake and the posting of one message at a time to internal firmware. The host raises a wake request in a control register that is always reachable. It polls a clock-status register until the core reports ready, then announces itself by writing a fixed wake pattern. Writing a different pattern later says the host allows sleep again.

To post a message, the host first stores a packed header word. The word holds a group identifier, an opcode and a total length. The host then sets the doorbell bit. The block hands the header to firmware with a strobe and keeps the doorbell set until an allocator offers a buffer address. On the edge that latches that address, the doorbell clears. The host polls the doorbell, reads the buffer address and copies its payload there. It then writes a completion word, which is the address shifted left by two with bit 1 set. The block turns that word into a completion strobe and an address for firmware.

A host access to any register other than the two wake registers is refused while the core is not ready. A doorbell that rings while a message is still pending is dropped and sets a sticky overflow flag.

Top module: `hwmb_top`

## Requirements
- R1: After reset every register reads zero, `host_rdata`, `host_err` and all strobes are low, and `core_wake`, `core_ready` and `msg_pending` are low.
- R2: Writing the control register (address 0x01) with bit 1 set sets `core_wake`, and this bit reads back at bit 1. Writing it with bit 1 clear drops `core_wake` and `core_ready` on that same edge. The control register and the clock-status register (0x02) are reachable at all times.
- R3: `core_ready` (clock-status bit 0) rises exactly WAKE_DLY clock cycles after the edge that set the wake bit, and it stays high while the wake bit stays set.
- R4: While `core_ready` is low, a read or write to any address other than 0x01 or 0x02 pulses `host_err` for one cycle. Such a write changes no state and such a read returns zero.
- R5: Writing 0x00005678 to the wake register (0x10) sets `host_awake` (readback bit 0) and pulses `fw_wake_irq`. Writing 0x00004321 clears it and pulses `fw_sleep_irq`. Any other value has no effect.
- R6: A write to the header register (0x14) stores the word with bit 15 forced to zero, and that is the value read back. When a doorbell is accepted, the stored word is presented as `msg_gid` = bits 7:0, `msg_opcode` = bits 15:8 and `msg_len` = bits 31:16. These outputs hold until the next accepted doorbell.
- R7: A write to the doorbell register (0x18) with bit 1 set, while no message is pending, sets `msg_pending` (readback bit 1) and pulses `fw_msg_irq` for one cycle.
- R8: While a message is pending, `alloc_valid` latches `alloc_addr` into the buffer-address register (0x1C), and `msg_pending` clears on that same edge. `alloc_valid` has no effect while nothing is pending.
- R9: A doorbell write while a message is pending is ignored: there is no strobe and the header outputs do not change. It sets a sticky overflow flag at doorbell readback bit 4, which only reset clears. The pending state used for this decision is the one from before the edge, even when `alloc_valid` arrives in the same cycle.
- R10: Writing the completion register (0x20) with bit 1 set pulses `fw_done_irq` and sets `done_addr` to write-data bits BUF_W+1:2. A write with bit 1 clear does neither.
- R11: Read data appears on `host_rdata` in the cycle after the read request and is zero in every other cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host register write request |
| host_rd | input | 1 | Host register read request |
| host_addr | input | 8 | Register address |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data, one cycle after the request |
| host_err | output | 1 | Access refused because the core is not ready |
| alloc_valid | input | 1 | Allocator offers a buffer address |
| alloc_addr | input | BUF_W | Offered buffer address |
| core_wake | output | 1 | Wake request held by the host |
| core_ready | output | 1 | Core clock reported ready |
| host_awake | output | 1 | Host has announced it is awake |
| fw_wake_irq | output | 1 | Strobe: wake pattern received |
| fw_sleep_irq | output | 1 | Strobe: sleep pattern received |
| fw_msg_irq | output | 1 | Strobe: doorbell accepted |
| msg_gid | output | 8 | Latched group identifier |
| msg_opcode | output | 8 | Latched opcode, bit 7 zero |
| msg_len | output | 16 | Latched total length |
| msg_pending | output | 1 | Doorbell set, waiting for a buffer |
| fw_done_irq | output | 1 | Strobe: host transmit complete |
| done_addr | output | BUF_W | Buffer address from the completion word |

## Verification
The doorbell write and the allocator's address offer can land in the same cycle, and the bench provokes this in both orders of state. The first case is a ring while a message is already pending, together with `alloc_valid`. The bench expects the pending flag to clear, the address to latch, the overflow flag to set and no new message strobe. The second case is a ring on an idle doorbell together with `alloc_valid`. Here the bench expects the message to be accepted and the offer to be ignored. The reference model judges both from the state before the edge and is compared with every output on every clock.

// File: rtl/hwmb_pkg.sv
package hwmb_pkg;

    localparam int HA_W = 8;
    localparam int DW   = 32;

    localparam logic [HA_W-1:0] A_CTRL  = 8'h01;
    localparam logic [HA_W-1:0] A_CLKST = 8'h02;
    localparam logic [HA_W-1:0] A_WAKE  = 8'h10;
    localparam logic [HA_W-1:0] A_HDR   = 8'h14;
    localparam logic [HA_W-1:0] A_BELL  = 8'h18;
    localparam logic [HA_W-1:0] A_BUF   = 8'h1C;
    localparam logic [HA_W-1:0] A_DONE  = 8'h20;

    localparam logic [DW-1:0] WAKE_WORD  = 32'h0000_5678;
    localparam logic [DW-1:0] SLEEP_WORD = 32'h0000_4321;

    typedef struct packed {
        logic [15:0] len;
        logic [7:0]  opc;
        logic [7:0]  gid;
    } msg_hdr_t;

endpackage

// File: rtl/hwmb_wake.sv
module hwmb_wake
    import hwmb_pkg::*;
#(
    parameter int WAKE_DLY = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctrl_wr,
    input  logic          ctrl_bit,
    input  logic          magic_wr,
    input  logic [DW-1:0] magic_word,
    output logic          wake_o,
    output logic          ready_o,
    output logic          awake_o,
    output logic          wake_irq_o,
    output logic          sleep_irq_o
);

    localparam int            CW      = $clog2(WAKE_DLY + 1);
    localparam logic [CW-1:0] CNT_TOP = CW'(WAKE_DLY);

    typedef struct packed {
        logic          wake;
        logic [CW-1:0] cnt;
        logic          awake;
        logic          wirq;
        logic          sirq;
    } wk_st_t;

    wk_st_t wk_q, wk_d;

    always_comb begin
        wk_d      = wk_q;
        wk_d.wirq = 1'b0;
        wk_d.sirq = 1'b0;
        if (ctrl_wr && !ctrl_bit) begin
            wk_d.wake = 1'b0;
            wk_d.cnt  = '0;
        end else begin
            if (ctrl_wr) begin
                wk_d.wake = 1'b1;
            end
            if (wk_q.wake && (wk_q.cnt != CNT_TOP)) begin
                wk_d.cnt = wk_q.cnt + 1'b1;
            end
        end
        if (magic_wr) begin
            if (magic_word == WAKE_WORD) begin
                wk_d.awake = 1'b1;
                wk_d.wirq  = 1'b1;
            end else if (magic_word == SLEEP_WORD) begin
                wk_d.awake = 1'b0;
                wk_d.sirq  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wk_q <= '0;
        end else begin
            wk_q <= wk_d;
        end
    end

    assign wake_o      = wk_q.wake;
    assign ready_o     = (wk_q.cnt == CNT_TOP);
    assign awake_o     = wk_q.awake;
    assign wake_irq_o  = wk_q.wirq;
    assign sleep_irq_o = wk_q.sirq;

    assert_ready_needs_wake_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |-> wake_o);

    assert_ready_after_wake_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_o) |-> $past(wake_o));

    assert_clear_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && !ctrl_bit) |=> (!wake_o && !ready_o));

    assert_one_pattern_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(wake_irq_o && sleep_irq_o));

endmodule

// File: rtl/hwmb_bell.sv
module hwmb_bell
    import hwmb_pkg::*;
#(
    parameter int BUF_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hdr_wr,
    input  logic [DW-1:0]    hdr_word,
    input  logic             bell_wr,
    input  logic             bell_bit,
    input  logic             alloc_valid,
    input  logic [BUF_W-1:0] alloc_addr,
    input  logic             done_wr,
    input  logic             done_flag,
    input  logic [BUF_W-1:0] done_word,
    output msg_hdr_t         hdr_o,
    output logic             pending_o,
    output logic             ovf_o,
    output logic             msg_irq_o,
    output msg_hdr_t         msg_o,
    output logic [BUF_W-1:0] buf_o,
    output logic             done_irq_o,
    output logic [BUF_W-1:0] done_addr_o
);

    typedef struct packed {
        msg_hdr_t         hdr;
        logic             pend;
        logic             ovf;
        logic             mirq;
        msg_hdr_t         msg;
        logic [BUF_W-1:0] bufa;
        logic             dirq;
        logic [BUF_W-1:0] daddr;
    } bl_st_t;

    bl_st_t bl_q, bl_d;
    logic   ring;

    always_comb begin
        bl_d      = bl_q;
        bl_d.mirq = 1'b0;
        bl_d.dirq = 1'b0;
        ring      = bell_wr && bell_bit;

        if (hdr_wr) begin
            bl_d.hdr        = msg_hdr_t'(hdr_word);
            bl_d.hdr.opc[7] = 1'b0;
        end

        if (ring && bl_q.pend) begin
            bl_d.ovf = 1'b1;
        end else if (ring) begin
            bl_d.pend = 1'b1;
            bl_d.mirq = 1'b1;
            bl_d.msg  = bl_q.hdr;
        end

        if (bl_q.pend && alloc_valid) begin
            bl_d.bufa = alloc_addr;
            bl_d.pend = 1'b0;
        end

        if (done_wr && done_flag) begin
            bl_d.dirq  = 1'b1;
            bl_d.daddr = done_word;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bl_q <= '0;
        end else begin
            bl_q <= bl_d;
        end
    end

    assign hdr_o       = bl_q.hdr;
    assign pending_o   = bl_q.pend;
    assign ovf_o       = bl_q.ovf;
    assign msg_irq_o   = bl_q.mirq;
    assign msg_o       = bl_q.msg;
    assign buf_o       = bl_q.bufa;
    assign done_irq_o  = bl_q.dirq;
    assign done_addr_o = bl_q.daddr;

    assert_clear_on_alloc_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pending_o && alloc_valid) |=> (!pending_o && (buf_o == $past(alloc_addr))));

    assert_msg_sets_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
        msg_irq_o |-> pending_o);

    assert_busy_ring_dropped_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pending_o && bell_wr && bell_bit) |=> (!msg_irq_o && ovf_o));

    assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |=> ovf_o);

    assert_done_needs_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq_o |-> $past(done_wr && done_flag));

endmodule

// File: rtl/hwmb_top.sv
module hwmb_top
    import hwmb_pkg::*;
#(
    parameter int WAKE_DLY = 4,
    parameter int BUF_W    = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_wr,
    input  logic             host_rd,
    input  logic [7:0]       host_addr,
    input  logic [31:0]      host_wdata,
    output logic [31:0]      host_rdata,
    output logic             host_err,
    input  logic             alloc_valid,
    input  logic [BUF_W-1:0] alloc_addr,
    output logic             core_wake,
    output logic             core_ready,
    output logic             host_awake,
    output logic             fw_wake_irq,
    output logic             fw_sleep_irq,
    output logic             fw_msg_irq,
    output logic [7:0]       msg_gid,
    output logic [7:0]       msg_opcode,
    output logic [15:0]      msg_len,
    output logic             msg_pending,
    output logic             fw_done_irq,
    output logic [BUF_W-1:0] done_addr
);

    typedef struct packed {
        logic [DW-1:0] rdata;
        logic          err;
    } hi_st_t;

    hi_st_t   hi_q, hi_d;
    logic     always_on, allow, wr_ok, rd_ok;
    msg_hdr_t hdr_view, msg_view;
    logic     ovf, wake_w, ready_w, awake_w;
    logic [BUF_W-1:0] buf_w;

    assign always_on = (host_addr == A_CTRL) || (host_addr == A_CLKST);
    assign allow     = ready_w || always_on;
    assign wr_ok     = host_wr && allow;
    assign rd_ok     = host_rd && allow;

    hwmb_wake #(.WAKE_DLY(WAKE_DLY)) u_wake (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctrl_wr     (wr_ok && (host_addr == A_CTRL)),
        .ctrl_bit    (host_wdata[1]),
        .magic_wr    (wr_ok && (host_addr == A_WAKE)),
        .magic_word  (host_wdata),
        .wake_o      (wake_w),
        .ready_o     (ready_w),
        .awake_o     (awake_w),
        .wake_irq_o  (fw_wake_irq),
        .sleep_irq_o (fw_sleep_irq)
    );

    hwmb_bell #(.BUF_W(BUF_W)) u_bell (
        .clk         (clk),
        .rst_n       (rst_n),
        .hdr_wr      (wr_ok && (host_addr == A_HDR)),
        .hdr_word    (host_wdata),
        .bell_wr     (wr_ok && (host_addr == A_BELL)),
        .bell_bit    (host_wdata[1]),
        .alloc_valid (alloc_valid),
        .alloc_addr  (alloc_addr),
        .done_wr     (wr_ok && (host_addr == A_DONE)),
        .done_flag   (host_wdata[1]),
        .done_word   (host_wdata[BUF_W+1:2]),
        .hdr_o       (hdr_view),
        .pending_o   (msg_pending),
        .ovf_o       (ovf),
        .msg_irq_o   (fw_msg_irq),
        .msg_o       (msg_view),
        .buf_o       (buf_w),
        .done_irq_o  (fw_done_irq),
        .done_addr_o (done_addr)
    );

    always_comb begin
        hi_d       = '0;
        hi_d.err   = (host_wr || host_rd) && !allow;
        if (rd_ok) begin
            unique case (host_addr)
                A_CTRL:  hi_d.rdata = {30'd0, wake_w, 1'b0};
                A_CLKST: hi_d.rdata = {31'd0, ready_w};
                A_WAKE:  hi_d.rdata = {31'd0, awake_w};
                A_HDR:   hi_d.rdata = hdr_view;
                A_BELL:  hi_d.rdata = {27'd0, ovf, 2'b00, msg_pending, 1'b0};
                A_BUF:   hi_d.rdata = DW'(buf_w);
                default: hi_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q <= '0;
        end else begin
            hi_q <= hi_d;
        end
    end

    assign host_rdata = hi_q.rdata;
    assign host_err   = hi_q.err;
    assign core_wake  = wake_w;
    assign core_ready = ready_w;
    assign host_awake = awake_w;
    assign msg_gid    = msg_view.gid;
    assign msg_opcode = msg_view.opc;
    assign msg_len    = msg_view.len;

    assert_err_only_unready_R4: assert property (@(posedge clk) disable iff (!rst_n)
        host_err |-> !$past(core_ready));

    assert_err_reads_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        host_err |-> (host_rdata == '0));

    assert_rdata_only_after_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rdata != '0) |-> $past(host_rd));

endmodule

// File: tb/sim_hwmb_top.sv
`timescale 1ns/1ps
module sim_hwmb_top;

    localparam int DLY   = 4;
    localparam int BUF_W = 24;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             host_wr = 1'b0, host_rd = 1'b0;
    logic [7:0]       host_addr = '0;
    logic [31:0]      host_wdata = '0;
    logic [31:0]      host_rdata;
    logic             host_err;
    logic             alloc_valid = 1'b0;
    logic [BUF_W-1:0] alloc_addr = '0;
    logic             core_wake, core_ready, host_awake;
    logic             fw_wake_irq, fw_sleep_irq, fw_msg_irq, msg_pending, fw_done_irq;
    logic [7:0]       msg_gid, msg_opcode;
    logic [15:0]      msg_len;
    logic [BUF_W-1:0] done_addr;

    always #4 clk = ~clk;

    hwmb_top #(.WAKE_DLY(DLY), .BUF_W(BUF_W)) u0 (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .host_err(host_err), .alloc_valid(alloc_valid), .alloc_addr(alloc_addr),
        .core_wake(core_wake), .core_ready(core_ready), .host_awake(host_awake),
        .fw_wake_irq(fw_wake_irq), .fw_sleep_irq(fw_sleep_irq), .fw_msg_irq(fw_msg_irq),
        .msg_gid(msg_gid), .msg_opcode(msg_opcode), .msg_len(msg_len),
        .msg_pending(msg_pending), .fw_done_irq(fw_done_irq), .done_addr(done_addr)
    );

    int checks = 0;
    int errors = 0;
    bit cmp_en = 1'b0;
    bit fin = 1'b0;
    string cur_tag = "R11";

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference model, updated on every rising edge
    int m_wake, m_cnt, m_awake, m_wirq, m_sirq, m_pend, m_ovf, m_mirq, m_dirq, m_err;
    logic [31:0] m_hdr, m_rdata, m_msg;
    int m_buf, m_daddr;
    string m_rtag = "R11";

    always @(posedge clk) begin
        if (!rst_n) begin
            m_wake = 0; m_cnt = 0; m_awake = 0; m_wirq = 0; m_sirq = 0;
            m_pend = 0; m_ovf = 0; m_mirq = 0; m_dirq = 0; m_err = 0;
            m_hdr = 0; m_rdata = 0; m_msg = 0; m_buf = 0; m_daddr = 0;
        end else begin
            bit ready, ok, wr, rd;
            int old_pend, old_wake;
            ready = (m_cnt == DLY);
            ok = ready || host_addr == 8'h01 || host_addr == 8'h02;
            wr = host_wr && ok;
            rd = host_rd && ok;
            m_err = (host_wr || host_rd) && !ok;
            m_rdata = 0;
            m_rtag = cur_tag;
            if (rd) begin
                case (host_addr)
                    8'h01: m_rdata = m_wake ? 32'h2 : 32'h0;
                    8'h02: m_rdata = ready ? 32'h1 : 32'h0;
                    8'h10: m_rdata = 32'(m_awake);
                    8'h14: m_rdata = m_hdr;
                    8'h18: m_rdata = (m_ovf ? 32'h10 : 0) | (m_pend ? 32'h2 : 0);
                    8'h1C: m_rdata = 32'(m_buf);
                    default: m_rdata = 0;
                endcase
            end
            old_wake = m_wake;
            if (wr && host_addr == 8'h01 && !host_wdata[1]) begin
                m_wake = 0; m_cnt = 0;
            end else begin
                if (wr && host_addr == 8'h01) m_wake = 1;
                if (old_wake != 0 && m_cnt < DLY) m_cnt++;
            end
            m_wirq = 0; m_sirq = 0;
            if (wr && host_addr == 8'h10) begin
                if (host_wdata == 32'h5678) begin m_awake = 1; m_wirq = 1; end
                else if (host_wdata == 32'h4321) begin m_awake = 0; m_sirq = 1; end
            end
            if (wr && host_addr == 8'h14) m_hdr = host_wdata & 32'hFFFF_7FFF;
            old_pend = m_pend;
            m_mirq = 0;
            if (wr && host_addr == 8'h18 && host_wdata[1]) begin
                if (old_pend != 0) m_ovf = 1;
                else begin m_pend = 1; m_mirq = 1; m_msg = m_hdr; end
            end
            if (old_pend != 0 && alloc_valid) begin
                m_buf = int'(alloc_addr); m_pend = 0;
            end
            m_dirq = 0;
            if (wr && host_addr == 8'h20 && host_wdata[1]) begin
                m_dirq = 1; m_daddr = int'(host_wdata[BUF_W+1:2]);
            end
        end
    end

    // full comparison on every clock, away from the active edge
    always @(negedge clk) begin
        if (cmp_en) begin
            chk(m_rtag, host_rdata, m_rdata);
            chk("R4 err", 32'(host_err), 32'(m_err));
            chk("R2 wake", 32'(core_wake), 32'(m_wake));
            chk("R3 ready", 32'(core_ready), 32'(m_cnt == DLY));
            chk("R5 awake", 32'(host_awake), 32'(m_awake));
            chk("R5 wake_irq", 32'(fw_wake_irq), 32'(m_wirq));
            chk("R5 sleep_irq", 32'(fw_sleep_irq), 32'(m_sirq));
            chk("R7 msg_irq", 32'(fw_msg_irq), 32'(m_mirq));
            chk("R8 pending", 32'(msg_pending), 32'(m_pend));
            chk("R6 header", {msg_len, msg_opcode, msg_gid}, m_msg);
            chk("R10 done_irq", 32'(fw_done_irq), 32'(m_dirq));
            chk("R10 done_addr", 32'(done_addr), 32'(m_daddr));
        end
    end

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !fin) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected<20000 cycles", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic op(input bit wr, input bit rd, input logic [7:0] a, input logic [31:0] d,
                      input bit av, input logic [BUF_W-1:0] aa, input string tag,
                      output logic [31:0] rv);
        @(negedge clk);
        host_wr = wr; host_rd = rd; host_addr = a; host_wdata = d;
        alloc_valid = av; alloc_addr = aa; cur_tag = tag;
        @(negedge clk);
        rv = host_rdata;
        host_wr = 0; host_rd = 0; alloc_valid = 0; cur_tag = "R11";
    endtask

    initial begin
        logic [31:0] v;
        int polls;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 rdata", host_rdata, 0);
        chk("R1 strobes", {fw_wake_irq, fw_sleep_irq, fw_msg_irq, fw_done_irq, host_err}, 0);
        chk("R1 state", {core_wake, core_ready, msg_pending, host_awake}, 0);
        cmp_en = 1'b1;

        // R4: refused accesses before ready
        op(0, 1, 8'h18, 0, 0, 0, "R4 read refused", v);
        chk("R4 read zero", v, 0);
        op(1, 0, 8'h14, 32'hDEAD_BEEF, 0, 0, "R4", v);
        op(0, 1, 8'h01, 0, 0, 0, "R1 ctrl reads zero", v);
        chk("R1 ctrl", v, 0);

        // R2/R3: wake and wait for ready
        op(1, 0, 8'h01, 32'h2, 0, 0, "R2", v);
        polls = 0;
        for (int i = 0; i < 20; i++) begin
            op(0, 1, 8'h02, 0, 0, 0, "R3 clkst", v);
            polls++;
            if (v[0]) break;
        end
        chk("R3 ready seen", v, 1);
        op(0, 1, 8'h01, 0, 0, 0, "R2 ctrl readback", v);
        chk("R2 ctrl readback", v, 32'h2);
        op(0, 1, 8'h14, 0, 0, 0, "R4 write dropped", v);
        chk("R4 dropped header", v, 0);

        // R5 wake patterns
        op(1, 0, 8'h10, 32'h0000_1234, 0, 0, "R5", v);
        op(1, 0, 8'h10, 32'h0000_5678, 0, 0, "R5", v);
        op(0, 1, 8'h10, 0, 0, 0, "R5 awake readback", v);
        chk("R5 awake", v, 1);

        // R8: idle allocator offer ignored
        op(0, 0, 8'h00, 0, 1, 24'h0000AA, "R8", v);
        op(0, 1, 8'h1C, 0, 0, 0, "R8 buf untouched", v);
        chk("R8 idle offer", v, 0);

        // R6/R7 header and doorbell
        op(1, 0, 8'h14, 32'h000C_B001, 0, 0, "R6", v);
        op(0, 1, 8'h14, 0, 0, 0, "R6 header readback", v);
        chk("R6 header masked", v, 32'h000C_3001);
        op(1, 0, 8'h18, 32'h2, 0, 0, "R7", v);
        chk("R7 pending", 32'(msg_pending), 1);
        chk("R6 fields", {msg_len, msg_opcode, msg_gid}, 32'h000C_3001);
        // R9 busy ring
        op(1, 0, 8'h14, 32'h0008_0202, 0, 0, "R6", v);
        op(1, 0, 8'h18, 32'h2, 0, 0, "R9", v);
        chk("R9 header held", {msg_len, msg_opcode, msg_gid}, 32'h000C_3001);
        // R8 host polling, allocator answers during the fourth poll
        polls = 0;
        for (int i = 0; i < 1000; i++) begin
            op(0, 1, 8'h18, 0, (i == 3), 24'h037AA0, "R8 poll", v);
            if (!v[1]) break;
            polls++;
        end
        chk("R8 poll count", 32'(polls), 4);
        chk("R9 ovf bit", v, 32'h10);
        op(0, 1, 8'h1C, 0, 0, 0, "R8 buf readback", v);
        chk("R8 buf addr", v, 32'h0003_7AA0);

        // R10 completion
        op(1, 0, 8'h20, 32'h000D_EA82, 0, 0, "R10", v);
        chk("R10 addr", 32'(done_addr), 32'h037AA0);
        op(1, 0, 8'h20, 32'h0000_0400, 0, 0, "R10 no flag", v);

        // collision: idle ring + offer -> accepted, offer ignored
        op(1, 0, 8'h18, 32'h2, 1, 24'h001111, "R9 idle collide", v);
        chk("R9 idle collide pending", 32'(msg_pending), 1);
        // collision: pending ring + offer -> cleared, latched, no strobe
        op(1, 0, 8'h18, 32'h2, 1, 24'h002222, "R9 busy collide", v);
        chk("R8 collide cleared", 32'(msg_pending), 0);
        op(0, 1, 8'h1C, 0, 0, 0, "R8 collide buf", v);
        chk("R8 collide buf", v, 32'h0000_2222);

        // R5 sleep, R2 wake drop, R4 refused again
        op(1, 0, 8'h10, 32'h0000_4321, 0, 0, "R5", v);
        op(1, 0, 8'h01, 32'h0, 0, 0, "R2", v);
        chk("R2 wake dropped", {core_wake, core_ready}, 0);
        op(0, 1, 8'h1C, 0, 0, 0, "R4 refused after sleep", v);
        chk("R4 zero after sleep", v, 0);
        op(0, 1, 8'h18, 0, 0, 0, "R11", v);
        repeat (3) @(negedge clk);

        fin = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule